// File: doc/BRIEF.md
# Slave-Mode Bitstream Load Sequencer

This block takes a downstream programmable device through its slave-mode configuration handshake and then reports how the attempt ended. A one-cycle start request picks one of two targets, the main device or the mezzanine device. If that target is marked absent, the block reports a code at once and leaves every pin alone. Otherwise it runs the full sequence. It optionally raises the target's enable pin and lets go of the open-drain INIT line. It then pulses the active-low PROGRAM line for a fixed number of cycles and waits, with a bounded timeout, for the device to pull INIT high. Next it passes the configuration image byte by byte from a valid/ready stream onto an 8-bit write port with a strobe. The end of the image is marked by a last flag on the stream. Finally it waits, with a second bounded timeout, for DONE to go high.

When the block is idle, it holds INIT low, which keeps the device from starting its own power-on configuration. The states are: `ST_IDLE`, waiting for start; `ST_ARM`, INIT released and enable raised; `ST_PROG`, PROGRAM low; `ST_WINIT`, polling INIT; `ST_WRITE`, streaming bytes; `ST_WDONE`, polling DONE; and `ST_FIN`, a one-cycle report.

The transitions are:
- IDLE to FIN on start with the target absent.
- IDLE to ARM on start with the target present.
- ARM to PROG always.
- PROG to WINIT after the low time.
- WINIT to WRITE when INIT is high.
- WINIT to FIN on the INIT timeout.
- WRITE to WDONE when the last byte is accepted.
- WDONE to FIN when DONE is high or on the DONE timeout.
- FIN to IDLE always.

Top module: `cfg_loader`

## Requirements
- R1: A start in ST_IDLE with the selected target absent (`sel_mezz_i`=0 selects main, 1 selects mezzanine) raises `fin_o` in the next cycle with `status_o`=1. `prog_n_o`, `init_oe_o` and `en_o` do not change.
- R2: While a load runs (from ST_ARM to ST_WDONE), `en_o` is high only if the selected target's use-enable input was high at start. Otherwise `en_o` stays low.
- R3: `init_oe_o` drops to 0 (INIT released) in ST_ARM, one cycle before PROGRAM goes low, and stays 0 until the load ends.
- R4: `prog_n_o` is low for exactly PROG_CYC consecutive cycles per load and high at all other times.
- R5: After PROGRAM rises, INIT is sampled once per cycle. If it is still low after INIT_TMO samples, the load ends with `status_o`=2, and no byte is accepted.
- R6: Each byte accepted in ST_WRITE (`s_valid_i` and `s_ready_o` high at a clock edge) appears on `wr_data_o` with `wr_stb_o` high for one cycle, one cycle after that edge, in stream order. An accepted byte with `s_last_i` high ends the image.
- R7: After the last byte, DONE is sampled once per cycle. If it is still low after DONE_TMO samples, the load ends with `status_o`=3.
- R8: If DONE is seen high within that window, the load ends with `status_o`=0.
- R9: `en_o` is low in the cycle `fin_o` is high and stays low while idle, whether the load succeeded or failed.
- R10: In ST_IDLE and ST_FIN, `init_oe_o` is 1, so INIT is held low.
- R11: `s_ready_o` is high only in ST_WRITE. A start request that arrives while a load is running has no effect on any output.
- R12: `fin_o` is a one-cycle pulse per load, and `status_o` keeps its value until the next pulse. After reset: `status_o`=0, `fin_o`=0, `prog_n_o`=1, `init_oe_o`=1, `en_o`=0, `s_ready_o`=0, `wr_stb_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| sel_mezz_i | input | 1 | Target select: 0 main, 1 mezzanine |
| main_present_i | input | 1 | Main target exists |
| mezz_present_i | input | 1 | Mezzanine target exists |
| main_use_en_i | input | 1 | Main target uses an enable pin |
| mezz_use_en_i | input | 1 | Mezzanine target uses an enable pin |
| init_i | input | 1 | Sampled INIT line level |
| done_pin_i | input | 1 | Sampled DONE line level |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | DATA_W | Byte stream data |
| s_last_i | input | 1 | Marks the final byte of the image |
| s_ready_o | output | 1 | Byte stream ready |
| prog_n_o | output | 1 | Active-low PROGRAM line |
| init_oe_o | output | 1 | Open-drain drive-low enable for INIT |
| en_o | output | 1 | Target enable pin |
| wr_data_o | output | DATA_W | Configuration write data |
| wr_stb_o | output | 1 | Configuration write strobe |
| status_o | output | 2 | Result code: 0 ok, 1 no target, 2 no INIT, 3 no DONE |
| fin_o | output | 1 | One-cycle end-of-load pulse |

## Verification
The pin outputs, `s_ready_o`, `fin_o` and `status_o` all follow the state register. They therefore change one edge after the input that caused them: `fin_o` with code 1 in the cycle after an absent-target start, and PROGRAM rising exactly PROG_CYC cycles after it fell. The write strobe comes from its own register stage and is due one cycle after the accepting edge. The bench's reference model advances on each rising edge from the inputs held across that edge, and it compares every output at the falling edge that follows. No check can therefore land on a cycle where the result is still in flight. The timeout boundaries are hit on purpose: INIT rises on the last permitted sample, and DONE never rises so that the full window runs out.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_PROG  = 3'd2,
        ST_WINIT = 3'd3,
        ST_WRITE = 3'd4,
        ST_WDONE = 3'd5,
        ST_FIN   = 3'd6
    } cfg_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_NOTGT  = 2'd1,
        RES_NOINIT = 2'd2,
        RES_NODONE = 2'd3
    } cfg_result_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hit on the cycle holding the limit-th sample of the current state.
    assign hit = (cnt_q == limit - 1'b1);

endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data <= '0;
            wr_stb  <= 1'b0;
        end else begin
            wr_stb <= take;
            if (take) begin
                wr_data <= din;
            end
        end
    end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned PROG_CYC = 20,
    parameter int unsigned INIT_TMO = 10_000_000,
    parameter int unsigned DONE_TMO = 100_000_000,
    parameter int          DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sel_mezz_i,
    input  logic              main_present_i,
    input  logic              mezz_present_i,
    input  logic              main_use_en_i,
    input  logic              mezz_use_en_i,
    input  logic              init_i,
    input  logic              done_pin_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              prog_n_o,
    output logic              init_oe_o,
    output logic              en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_stb_o,
    output logic [1:0]        status_o,
    output logic              fin_o
);
    localparam int unsigned MAX_LIM = max3(PROG_CYC, INIT_TMO, DONE_TMO);
    localparam int          CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] LIM_PROG = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] LIM_INIT = CNT_W'(INIT_TMO);
    localparam logic [CNT_W-1:0] LIM_DONE = CNT_W'(DONE_TMO);

    cfg_state_e  state_q, state_d;
    cfg_result_e result_q, result_d;
    logic        use_en_q, use_en_d;
    logic        tgt_present, tgt_use_en;
    logic        tmr_clr, tmr_hit;
    logic [CNT_W-1:0] tmr_limit;
    logic        take;

    assign tgt_present = sel_mezz_i ? mezz_present_i : main_present_i;
    assign tgt_use_en  = sel_mezz_i ? mezz_use_en_i  : main_use_en_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= RES_OK;
            use_en_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            use_en_q <= use_en_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        use_en_d = use_en_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!tgt_present) begin
                        result_d = RES_NOTGT;
                        state_d  = ST_FIN;
                    end else begin
                        use_en_d = tgt_use_en;
                        state_d  = ST_ARM;
                    end
                end
            end
            ST_ARM:   state_d = ST_PROG;
            ST_PROG:  if (tmr_hit) state_d = ST_WINIT;
            ST_WINIT: begin
                if (init_i) begin
                    state_d = ST_WRITE;
                end else if (tmr_hit) begin
                    result_d = RES_NOINIT;
                    state_d  = ST_FIN;
                end
            end
            ST_WRITE: if (s_valid_i && s_last_i) state_d = ST_WDONE;
            ST_WDONE: begin
                if (done_pin_i) begin
                    result_d = RES_OK;
                    state_d  = ST_FIN;
                end else if (tmr_hit) begin
                    result_d = RES_NODONE;
                    state_d  = ST_FIN;
                end
            end
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        prog_n_o  = 1'b1;
        init_oe_o = 1'b0;
        en_o      = 1'b0;
        s_ready_o = 1'b0;
        fin_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:  init_oe_o = 1'b1;
            ST_ARM:   en_o = use_en_q;
            ST_PROG: begin
                en_o     = use_en_q;
                prog_n_o = 1'b0;
            end
            ST_WINIT: en_o = use_en_q;
            ST_WRITE: begin
                en_o      = use_en_q;
                s_ready_o = 1'b1;
            end
            ST_WDONE: en_o = use_en_q;
            ST_FIN: begin
                init_oe_o = 1'b1;
                fin_o     = 1'b1;
            end
            default:  init_oe_o = 1'b1;
        endcase
    end

    assign status_o = result_q;

    // Shared wait counter: restarts on every state change
    assign tmr_clr = (state_d != state_q);

    always_comb begin
        unique case (state_q)
            ST_PROG:  tmr_limit = LIM_PROG;
            ST_WINIT: tmr_limit = LIM_INIT;
            default:  tmr_limit = LIM_DONE;
        endcase
    end

    cfg_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    assign take = (state_q == ST_WRITE) && s_valid_i;

    cfg_byte_port #(.DATA_W(DATA_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .din     (s_data_i),
        .wr_data (wr_data_o),
        .wr_stb  (wr_stb_o)
    );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              sel_mezz_i,
    input logic              main_present_i,
    input logic              mezz_present_i,
    input logic              s_valid_i,
    input logic [DATA_W-1:0] s_data_i,
    input logic              s_ready_o,
    input logic              prog_n_o,
    input logic              init_oe_o,
    input logic              en_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              wr_stb_o,
    input logic [1:0]        status_o,
    input logic              fin_o
);
    logic idle_obs;
    assign idle_obs = init_oe_o && !fin_o;

    // R1: absent target reports code 1 in the next cycle
    a_r1_absent_target: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle_obs && !(sel_mezz_i ? mezz_present_i : main_present_i))
        |=> (fin_o && status_o == 2'd1 && prog_n_o && init_oe_o && !en_o));

    // R2: enable only while INIT is released
    a_r2_en_inside_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> !init_oe_o);

    // R3: PROGRAM low only with INIT released
    a_r3_prog_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !init_oe_o);

    // R6: accepted byte shows on the write port one cycle later
    a_r6_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && s_ready_o) |=> (wr_stb_o && wr_data_o == $past(s_data_i)));

    // R9: enable low at the end of a load
    a_r9_en_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> !en_o);

    // R10: INIT held after a load ends
    a_r10_init_held: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> init_oe_o);

    // R11: ready only while PROGRAM is high and INIT is released
    a_r11_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (prog_n_o && !init_oe_o && !fin_o));

    // R12: single-cycle finish pulse, status held between pulses
    a_r12_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);

    a_r12_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_o |-> $stable(status_o));

endmodule

bind cfg_loader cfg_loader_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sel_mezz_i     (sel_mezz_i),
    .main_present_i (main_present_i),
    .mezz_present_i (mezz_present_i),
    .s_valid_i      (s_valid_i),
    .s_data_i       (s_data_i),
    .s_ready_o      (s_ready_o),
    .prog_n_o       (prog_n_o),
    .init_oe_o      (init_oe_o),
    .en_o           (en_o),
    .wr_data_o      (wr_data_o),
    .wr_stb_o       (wr_stb_o),
    .status_o       (status_o),
    .fin_o          (fin_o)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
    localparam int PROG_CYC = 5;
    localparam int INIT_TMO = 12;
    localparam int DONE_TMO = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, sel_mezz_i = 0;
    logic main_present_i = 1, mezz_present_i = 1;
    logic main_use_en_i = 1, mezz_use_en_i = 0;
    logic init_ext = 0, done_ext = 0;
    logic init_i, done_pin_i;
    logic s_valid_i = 0, s_last_i = 0;
    logic [DW-1:0] s_data_i = '0;
    logic s_ready_o, prog_n_o, init_oe_o, en_o, wr_stb_o, fin_o;
    logic [DW-1:0] wr_data_o;
    logic [1:0] status_o;

    // Open-drain INIT: low whenever the block drives it
    assign init_i     = init_oe_o ? 1'b0 : init_ext;
    assign done_pin_i = done_ext;

    always #10 clk = ~clk;

    cfg_loader #(.PROG_CYC(PROG_CYC), .INIT_TMO(INIT_TMO), .DONE_TMO(DONE_TMO),
                 .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_mezz_i(sel_mezz_i),
        .main_present_i(main_present_i), .mezz_present_i(mezz_present_i),
        .main_use_en_i(main_use_en_i), .mezz_use_en_i(mezz_use_en_i),
        .init_i(init_i), .done_pin_i(done_pin_i), .s_valid_i(s_valid_i),
        .s_data_i(s_data_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
        .prog_n_o(prog_n_o), .init_oe_o(init_oe_o), .en_o(en_o),
        .wr_data_o(wr_data_o), .wr_stb_o(wr_stb_o), .status_o(status_o), .fin_o(fin_o)
    );

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    // phase: 0 idle, 1 arm, 2 prog low, 3 wait init, 4 write, 5 wait done, 6 finish
    int m_phase = 0, m_cnt = 0, m_status = 0;
    bit m_use = 0, m_stb = 0;
    int m_data = 0;
    int m_written[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_status = 0; m_use = 0; m_stb = 0; m_data = 0;
        end else begin
            m_stb = (m_phase == 4) && s_valid_i;
            if (m_stb) begin
                m_data = s_data_i;
                m_written.push_back(int'(s_data_i));
            end
            case (m_phase)
                0: if (start_i) begin
                    if (!(sel_mezz_i ? mezz_present_i : main_present_i)) begin
                        m_status = 1; m_phase = 6;
                    end else begin
                        m_use = sel_mezz_i ? mezz_use_en_i : main_use_en_i;
                        m_phase = 1;
                    end
                end
                1: begin m_phase = 2; m_cnt = 0; end
                2: if (m_cnt == PROG_CYC - 1) begin m_phase = 3; m_cnt = 0; end
                   else m_cnt++;
                3: if (init_i) m_phase = 4;
                   else if (m_cnt == INIT_TMO - 1) begin m_status = 2; m_phase = 6; end
                   else m_cnt++;
                4: if (s_valid_i && s_last_i) begin m_phase = 5; m_cnt = 0; end
                5: if (done_pin_i) begin m_status = 0; m_phase = 6; end
                   else if (m_cnt == DONE_TMO - 1) begin m_status = 3; m_phase = 6; end
                   else m_cnt++;
                default: m_phase = 0;
            endcase
        end
    end

    // Compare every cycle, away from the active edge
    int prog_low_run = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R4 prog_n", prog_n_o, (m_phase == 2) ? 0 : 1);
            chk("R3/R10 init_oe", init_oe_o, (m_phase == 0 || m_phase == 6) ? 1 : 0);
            chk("R2/R9 en", en_o, (m_use && m_phase >= 1 && m_phase <= 5) ? 1 : 0);
            chk("R11 ready", s_ready_o, (m_phase == 4) ? 1 : 0);
            chk("R12 fin", fin_o, (m_phase == 6) ? 1 : 0);
            chk("R5/R7/R8 status", status_o, m_status);
            chk("R6 wr_stb", wr_stb_o, m_stb);
            if (m_stb) chk("R6 wr_data", wr_data_o, m_data);
            // R4: independent low-time measurement
            if (!prog_n_o) prog_low_run++;
            else begin
                if (prog_low_run != 0) chk("R4 prog low length", prog_low_run, PROG_CYC);
                prog_low_run = 0;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input bit sel);
        start_i = 1; sel_mezz_i = sel;
        tick(1);
        start_i = 0;
    endtask

    task automatic wait_fin();
        while (!fin_o) tick(1);
    endtask

    task automatic wait_prog_rise();
        while (prog_n_o) tick(1);
        while (!prog_n_o) tick(1);
    endtask

    task automatic send_byte(input logic [DW-1:0] b, input bit last, input bit gap);
        bit was_rdy;
        s_valid_i = 1; s_data_i = b; s_last_i = last;
        forever begin
            was_rdy = s_ready_o;
            tick(1);
            if (was_rdy) break;
        end
        s_valid_i = 0; s_last_i = 0;
        if (gap) tick(1);
    endtask

    initial begin
        int n0;
        tick(1);
        // R12 reset state
        chk("R12 reset prog_n", prog_n_o, 1);
        chk("R12 reset init_oe", init_oe_o, 1);
        chk("R12 reset en", en_o, 0);
        chk("R12 reset status", status_o, 0);
        chk("R12 reset fin", fin_o, 0);
        chk("R12 reset ready", s_ready_o, 0);
        tick(2);
        rst_n = 1;
        tick(2);

        // Load 1: main, enable used, bytes with gaps, early valid, start while busy
        n0 = m_written.size();
        s_valid_i = 1; s_data_i = 8'hA5; s_last_i = 0;   // R11: no take before write
        do_start(0);
        tick(2);
        chk("R11 no early write", m_written.size() - n0, 0);
        wait_prog_rise();
        tick(2);
        init_ext = 1;
        send_byte(8'hA5, 0, 1);
        do_start(0);                                     // R11: ignored while busy
        send_byte(8'h3C, 0, 0);
        send_byte(8'hFF, 0, 1);
        send_byte(8'h01, 1, 0);
        tick(2);
        done_ext = 1;
        wait_fin();
        chk("R8 success status", status_o, 0);
        chk("R6 byte count", m_written.size() - n0, 4);
        chk("R6 first byte", m_written[n0], 8'hA5);
        chk("R6 last byte", m_written[n0 + 3], 8'h01);
        done_ext = 0; init_ext = 0;
        tick(3);

        // Load 2: mezzanine absent
        mezz_present_i = 0;
        do_start(1);
        chk("R1 fin", fin_o, 1);
        chk("R1 status", status_o, 1);
        chk("R1 prog untouched", prog_n_o, 1);
        chk("R1 init untouched", init_oe_o, 1);
        chk("R1 en untouched", en_o, 0);
        tick(3);
        chk("R12 status held", status_o, 1);

        // Load 3: mezzanine present without enable, INIT never rises
        mezz_present_i = 1;
        do_start(1);
        wait_fin();
        chk("R5 no init status", status_o, 2);
        chk("R9 en low at end", en_o, 0);
        tick(3);

        // Load 4: main, INIT on the final permitted sample, DONE never rises
        do_start(0);
        wait_prog_rise();
        tick(INIT_TMO - 1);
        init_ext = 1;
        send_byte(8'h5A, 0, 0);
        send_byte(8'hC3, 1, 0);
        wait_fin();
        chk("R7 no done status", status_o, 3);
        chk("R9 en low after fail", en_o, 0);
        init_ext = 0;
        tick(3);
        chk("R10 idle init held", init_oe_o, 1);

        // Load 5: main without enable, immediate success
        main_use_en_i = 0;
        do_start(0);
        wait_prog_rise();
        init_ext = 1;
        done_ext = 1;
        send_byte(8'h77, 1, 0);
        wait_fin();
        chk("R8 quick success", status_o, 0);
        init_ext = 0; done_ext = 0;
        tick(4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule